// File: doc/BRIEF.md
# Dual-Ring Frame DMA Engine

This engine moves time-division multiplexed data for a two-channel, byte-interleaved line between the line interface and system memory. Each frame strobe starts one transfer in each direction. The transmit side reads one 32-bit word and places two channel bytes on the outgoing lanes. The receive side packs the two incoming channel bytes into one word and writes it back to memory. Each direction walks its own circular address ring. The rings run side by side and never stop on their own.

Software programs a start, a mid-point and an end byte address for each ring through a small indexed register bus, and it can read back the current address. The mid-point and end events of each ring latch into a status register. The status bits are cleared by writing ones, and a mask selects which of them drive the interrupt line. A control bit starts and stops both rings together. While the rings are stopped, the transmit lanes carry an all-ones idle pattern.

Top module: `rdma_engine`

## Requirements
- R1: After reset, both current-address registers read 0 and the status register reads 0. irq and mem_req are low, and tx_ch1 and tx_ch2 both show 0xFF.
- R2: Writing 1 to bit 0 of the control register (index 0) while stopped loads each ring's current address from its start register. While bit 0 is 0, tx_ch1 and tx_ch2 show 0xFF.
- R3: While running, each frame_strobe that arrives when no transfer is pending causes two transfers. The first is a read (mem_we=0) at the transmit current address, and the second is a write (mem_we=1) at the receive current address. Each request is held until mem_ack, and afterwards each current address has grown by 4. Register indices: transmit start/mid/end/current are 3/4/5/6, and receive start/mid/end/current are 7/8/9/10.
- R4: After the transfer at a ring's end address completes, that ring's current address reloads from its start register.
- R5: tx_ch1 carries bits 7:0 and tx_ch2 carries bits 15:8 of the last word read. The write carries rx_ch1 in bits 7:0 and rx_ch2 in bits 15:8 with mem_be = 4'b0011, so bits 31:16 of the memory word keep their value.
- R6: Status register (index 1) bits latch when the transfer at the matching address completes, and they stay set: bit 0 transmit mid-point, bit 1 transmit end, bit 2 receive mid-point, bit 3 receive end.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: irq equals the OR of status bits 3:0 ANDed with the mask register (index 2, bits 3:0). It follows one clock after the status change.
- R9: A frame_strobe that arrives while the transfer pair of an earlier strobe is still pending sets status bit 4 and is otherwise dropped, with no extra transfer.
- R10: Writes to start, mid-point or end registers while running leave the active ring unchanged until its next wrap, which uses the new values.
- R11: While stopped, frame_strobe is ignored: no memory request is made and both current addresses keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the indexed register |
| frame_strobe | input | 1 | One-cycle frame pulse |
| rx_ch1 | input | 8 | Incoming byte, channel 1 |
| rx_ch2 | input | 8 | Incoming byte, channel 2 |
| tx_ch1 | output | 8 | Outgoing byte, channel 1 |
| tx_ch2 | output | 8 | Outgoing byte, channel 2 |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| irq | output | 1 | Interrupt request |

## Verification
Randomised frames use random channel bytes and memory latencies of zero to three cycles. They show whether the bytes land in the right lanes and whether the read-then-write order and the address steps hold when the acknowledge timing varies. Each ring is given a different length, so the two rings wrap at different times and a bug that couples them shows up. Directed cases cover the rest. A second strobe inside a slow transfer separates dropping from queuing. A timed frame onto the receive mid-point pins the interrupt latency to one cycle. A rewrite of the transmit ring while running shows whether new bounds wait for the wrap. Stopping and restarting separates holding the addresses from reloading them.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    localparam int NDIR  = 2;   // ring count: transmit, receive
    localparam int NCFG  = 3;   // programmable bounds per ring
    localparam int NSRC  = 4;   // maskable interrupt sources
    localparam int NSTAT = NSRC + 1;

    localparam int DIR_TX = 0;
    localparam int DIR_RX = 1;

    localparam int CFG_START = 0;
    localparam int CFG_MID   = 1;
    localparam int CFG_END   = 2;

    localparam int RIDX_W = 4;
    localparam logic [RIDX_W-1:0] RA_CTRL = 4'd0;
    localparam logic [RIDX_W-1:0] RA_STAT = 4'd1;
    localparam logic [RIDX_W-1:0] RA_MASK = 4'd2;
    localparam int RA_DIR_BASE   = 3;
    localparam int RA_DIR_STRIDE = 4;
    localparam int RA_CUR_OFS    = 3;

    localparam int ST_OVERRUN = NSRC;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_TX_RD = 2'd1,
        SQ_RX_WR = 2'd2
    } seq_state_e;

    function automatic logic [RIDX_W-1:0] cfg_index(input int dir, input int k);
        return RIDX_W'(RA_DIR_BASE + RA_DIR_STRIDE * dir + k);
    endfunction

    function automatic logic [RIDX_W-1:0] cur_index(input int dir);
        return RIDX_W'(RA_DIR_BASE + RA_DIR_STRIDE * dir + RA_CUR_OFS);
    endfunction

endpackage

// File: rtl/rdma_ring.sv
module rdma_ring #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] cfg_start,
    input  logic [AW-1:0] cfg_mid,
    input  logic [AW-1:0] cfg_end,
    output logic [AW-1:0] cur,
    output logic          hit_mid,
    output logic          hit_end
);

    typedef struct packed {
        logic [AW-1:0] cur;
        logic [AW-1:0] mid;
        logic [AW-1:0] fin;
    } ring_t;

    ring_t ring_d, ring_q;
    logic  at_end;

    always_comb begin
        ring_d  = ring_q;
        at_end  = (ring_q.cur == ring_q.fin);
        hit_mid = step && (ring_q.cur == ring_q.mid);
        hit_end = step && at_end;
        if (load) begin
            ring_d.cur = cfg_start;
            ring_d.mid = cfg_mid;
            ring_d.fin = cfg_end;
        end else if (step) begin
            if (at_end) begin
                ring_d.cur = cfg_start;
                ring_d.mid = cfg_mid;
                ring_d.fin = cfg_end;
            end else begin
                ring_d.cur = ring_q.cur + AW'(STEP);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign cur = ring_q.cur;

endmodule

// File: rtl/rdma_seq.sv
module rdma_seq
    import rdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            strobe,
    input  logic            refill,
    input  logic [LW-1:0]   rx_a,
    input  logic [LW-1:0]   rx_b,
    input  logic [AW-1:0]   tx_addr,
    input  logic [AW-1:0]   rx_addr,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [DW/8-1:0] mem_be,
    output logic            tx_step,
    output logic            rx_step,
    output logic            overrun,
    output logic [LW-1:0]   tx_a,
    output logic [LW-1:0]   tx_b
);

    localparam int BE_W      = DW / 8;
    localparam int LANE_BYTES = 2 * LW / 8;

    typedef struct packed {
        seq_state_e    state;
        logic [LW-1:0] rxa;
        logic [LW-1:0] rxb;
        logic [LW-1:0] txa;
        logic [LW-1:0] txb;
    } seq_t;

    seq_t seq_d, seq_q;
    logic rdata_unused;

    assign rdata_unused = ^mem_rdata[DW-1:2*LW];

    always_comb begin
        seq_d   = seq_q;
        tx_step = 1'b0;
        rx_step = 1'b0;
        overrun = 1'b0;
        unique case (seq_q.state)
            SQ_IDLE: begin
                if (strobe && en) begin
                    seq_d.rxa   = rx_a;
                    seq_d.rxb   = rx_b;
                    seq_d.state = SQ_TX_RD;
                end
            end
            SQ_TX_RD: begin
                if (mem_ack) begin
                    tx_step     = 1'b1;
                    seq_d.txa   = mem_rdata[LW-1:0];
                    seq_d.txb   = mem_rdata[2*LW-1:LW];
                    seq_d.state = SQ_RX_WR;
                end
            end
            SQ_RX_WR: begin
                if (mem_ack) begin
                    rx_step     = 1'b1;
                    seq_d.state = SQ_IDLE;
                end
            end
            default: seq_d.state = SQ_IDLE;
        endcase
        if (strobe && en && (seq_q.state != SQ_IDLE)) begin
            overrun = 1'b1;
        end
        if (refill) begin
            seq_d.txa = '1;
            seq_d.txb = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= SQ_IDLE;
            seq_q.rxa   <= '0;
            seq_q.rxb   <= '0;
            seq_q.txa   <= '1;
            seq_q.txb   <= '1;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        mem_req   = (seq_q.state != SQ_IDLE);
        mem_we    = (seq_q.state == SQ_RX_WR);
        mem_addr  = mem_we ? rx_addr : tx_addr;
        mem_wdata = '0;
        mem_wdata[LW-1:0]    = seq_q.rxa;
        mem_wdata[2*LW-1:LW] = seq_q.rxb;
        for (int i = 0; i < BE_W; i++) begin
            mem_be[i] = (i < LANE_BYTES);
        end
    end

    assign tx_a = seq_q.txa;
    assign tx_b = seq_q.txb;

endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
    import rdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    input  logic              frame_strobe,
    input  logic [LW-1:0]     rx_ch1,
    input  logic [LW-1:0]     rx_ch2,
    output logic [LW-1:0]     tx_ch1,
    output logic [LW-1:0]     tx_ch2,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic [DW/8-1:0]   mem_be,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              irq
);

    typedef struct packed {
        logic                               en;
        logic [NSTAT-1:0]                   stat;
        logic [NSRC-1:0]                    mask;
        logic [NDIR-1:0][NCFG-1:0][AW-1:0]  cfg;
        logic                               irq;
    } eng_t;

    eng_t st_d, st_q;

    logic                     en_rise;
    logic [NDIR-1:0]          step_v;
    logic [NDIR-1:0]          hit_mid_v;
    logic [NDIR-1:0]          hit_end_v;
    logic [NDIR-1:0][AW-1:0]  cur_v;
    logic                     tx_step;
    logic                     rx_step;
    logic                     overrun;
    logic [LW-1:0]            lane_a;
    logic [LW-1:0]            lane_b;

    assign en_rise = reg_we && (reg_addr == RA_CTRL) && reg_wdata[0] && !st_q.en;
    assign step_v[DIR_TX] = tx_step;
    assign step_v[DIR_RX] = rx_step;

    for (genvar g = 0; g < NDIR; g++) begin : g_ring
        rdma_ring #(
            .AW   (AW),
            .STEP (DW / 8)
        ) u_ring (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (en_rise),
            .step      (step_v[g]),
            .cfg_start (st_q.cfg[g][CFG_START]),
            .cfg_mid   (st_q.cfg[g][CFG_MID]),
            .cfg_end   (st_q.cfg[g][CFG_END]),
            .cur       (cur_v[g]),
            .hit_mid   (hit_mid_v[g]),
            .hit_end   (hit_end_v[g])
        );
    end

    rdma_seq #(
        .AW (AW),
        .DW (DW),
        .LW (LW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (st_q.en),
        .strobe    (frame_strobe),
        .refill    (en_rise),
        .rx_a      (rx_ch1),
        .rx_b      (rx_ch2),
        .tx_addr   (cur_v[DIR_TX]),
        .rx_addr   (cur_v[DIR_RX]),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_be    (mem_be),
        .tx_step   (tx_step),
        .rx_step   (rx_step),
        .overrun   (overrun),
        .tx_a      (lane_a),
        .tx_b      (lane_b)
    );

    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            if (reg_addr == RA_CTRL) begin
                st_d.en = reg_wdata[0];
            end
            if (reg_addr == RA_STAT) begin
                st_d.stat = st_q.stat & ~reg_wdata[NSTAT-1:0];
            end
            if (reg_addr == RA_MASK) begin
                st_d.mask = reg_wdata[NSRC-1:0];
            end
            for (int d = 0; d < NDIR; d++) begin
                for (int k = 0; k < NCFG; k++) begin
                    if (reg_addr == cfg_index(d, k)) begin
                        st_d.cfg[d][k] = reg_wdata;
                    end
                end
            end
        end
        for (int d = 0; d < NDIR; d++) begin
            if (hit_mid_v[d]) st_d.stat[2*d]     = 1'b1;
            if (hit_end_v[d]) st_d.stat[2*d + 1] = 1'b1;
        end
        if (overrun) st_d.stat[ST_OVERRUN] = 1'b1;
        st_d.irq = |(st_q.stat[NSRC-1:0] & st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == RA_CTRL) reg_rdata[0] = st_q.en;
        if (reg_addr == RA_STAT) reg_rdata[NSTAT-1:0] = st_q.stat;
        if (reg_addr == RA_MASK) reg_rdata[NSRC-1:0] = st_q.mask;
        for (int d = 0; d < NDIR; d++) begin
            for (int k = 0; k < NCFG; k++) begin
                if (reg_addr == cfg_index(d, k)) reg_rdata = st_q.cfg[d][k];
            end
            if (reg_addr == cur_index(d)) reg_rdata = cur_v[d];
        end
    end

    assign tx_ch1 = st_q.en ? lane_a : '1;
    assign tx_ch2 = st_q.en ? lane_b : '1;
    assign irq    = st_q.irq;

endmodule

// File: rtl/rdma_engine_chk.sv
module rdma_engine_chk #(
    parameter int AW    = 32,
    parameter int LW    = 8,
    parameter int BE_W  = 4,
    parameter int NSRC  = 4,
    parameter int NSTAT = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             reg_we,
    input logic             frame_strobe,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic [BE_W-1:0]  mem_be,
    input logic [LW-1:0]    tx_ch1,
    input logic [LW-1:0]    tx_ch2,
    input logic [NSTAT-1:0] stat,
    input logic [NSRC-1:0]  mask,
    input logic             irq
);

    localparam logic [BE_W-1:0] BE_LANES = BE_W'((1 << (2 * LW / 8)) - 1);

    AST_IDLE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (tx_ch1 == '1 && tx_ch2 == '1)); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we)); // R3

    AST_WRITE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_be == BE_LANES); // R5

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_we) |-> ((stat & $past(stat)) == $past(stat))); // R7

    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(stat[NSRC-1:0] & mask))); // R8

    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[NSTAT-1]) |-> $past(frame_strobe && mem_req)); // R9

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !mem_req |=> !mem_req); // R11

endmodule

bind rdma_engine rdma_engine_chk #(
    .AW    (AW),
    .LW    (LW),
    .BE_W  (DW / 8),
    .NSRC  (rdma_pkg::NSRC),
    .NSTAT (rdma_pkg::NSTAT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (st_q.en),
    .reg_we       (reg_we),
    .frame_strobe (frame_strobe),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_ack      (mem_ack),
    .mem_be       (mem_be),
    .tx_ch1       (tx_ch1),
    .tx_ch2       (tx_ch2),
    .stat         (st_q.stat),
    .mask         (st_q.mask),
    .irq          (irq)
);

// File: tb/tb_rdma_engine.sv
`timescale 1ns/1ps
module tb_rdma_engine;

    localparam logic [3:0] I_CTRL = 4'd0, I_STAT = 4'd1, I_MASK = 4'd2;
    localparam logic [3:0] I_TX_START = 4'd3, I_TX_MID = 4'd4, I_TX_END = 4'd5, I_TX_CUR = 4'd6;
    localparam logic [3:0] I_RX_START = 4'd7, I_RX_MID = 4'd8, I_RX_END = 4'd9, I_RX_CUR = 4'd10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        frame_strobe = 1'b0;
    logic [7:0]  rx_ch1 = '0;
    logic [7:0]  rx_ch2 = '0;
    logic [7:0]  tx_ch1, tx_ch2;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        irq;

    always #4 clk = ~clk;

    rdma_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_strobe(frame_strobe),
        .rx_ch1(rx_ch1), .rx_ch2(rx_ch2), .tx_ch1(tx_ch1), .tx_ch2(tx_ch2),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    int          mlat = 0;
    logic [31:0] bm [64];
    bit          log_we [512];
    logic [31:0] log_addr [512];
    logic [3:0]  log_be [512];
    int          log_n = 0;

    logic [31:0] p_start [2], p_mid [2], p_end [2];
    logic [31:0] m_cur [2], m_amid [2], m_aend [2];
    logic [4:0]  exp_stat = '0;

    // memory model: acknowledges after mlat waiting cycles, honours byte enables
    initial begin
        int cnt;
        int idx;
        cnt = 0;
        void'($urandom(32'd11));
        for (int i = 0; i < 64; i++) bm[i] = {16'hC000 | 16'(i), 16'($urandom)};
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_req) begin
                if (cnt >= mlat) begin
                    idx = int'(mem_addr[7:2]);
                    mem_ack = 1'b1;
                    mem_rdata = bm[idx];
                    if (mem_we) begin
                        for (int b = 0; b < 4; b++)
                            if (mem_be[b]) bm[idx][8*b +: 8] = mem_wdata[8*b +: 8];
                    end
                    log_we[log_n] = mem_we;
                    log_addr[log_n] = mem_addr;
                    log_be[log_n] = mem_be;
                    log_n++;
                    cnt = 0;
                end else begin
                    mem_ack = 1'b0;
                    cnt++;
                end
            end else begin
                mem_ack = 1'b0;
                cnt = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic model_adv(input int d, output bit wrapped);
        wrapped = 1'b0;
        if (m_cur[d] == m_amid[d]) exp_stat[2*d] = 1'b1;
        if (m_cur[d] == m_aend[d]) begin
            exp_stat[2*d+1] = 1'b1;
            m_cur[d] = p_start[d]; m_amid[d] = p_mid[d]; m_aend[d] = p_end[d];
            wrapped = 1'b1;
        end else begin
            m_cur[d] = m_cur[d] + 32'd4;
        end
    endtask

    task automatic model_load();
        for (int d = 0; d < 2; d++) begin
            m_cur[d] = p_start[d]; m_amid[d] = p_mid[d]; m_aend[d] = p_end[d];
        end
    endtask

    task automatic do_xfer(input int lat, input bit dbl, input string tag);
        int n0, ti, ri;
        logic [7:0] a, b;
        logic [31:0] v;
        bit w0, w1;
        mlat = lat;
        a = 8'($urandom); b = 8'($urandom);
        rx_ch1 = a; rx_ch2 = b;
        n0 = log_n;
        @(negedge clk) frame_strobe = 1'b1;
        @(negedge clk) frame_strobe = 1'b0;
        if (dbl) begin
            @(negedge clk) frame_strobe = 1'b1;
            @(negedge clk) frame_strobe = 1'b0;
        end
        repeat (14) @(negedge clk);
        chk(log_n == n0 + 2, dbl ? "R9" : "R3", "transfers per strobe", 32'(log_n - n0), 32'd2);
        if (log_n >= n0 + 2) begin
            chk(!log_we[n0] && log_addr[n0] == m_cur[0], "R3", "first is read at tx address",
                log_addr[n0], m_cur[0]);
            chk(log_we[n0+1] && log_addr[n0+1] == m_cur[1], "R3", "second is write at rx address",
                log_addr[n0+1], m_cur[1]);
            chk(log_be[n0+1] == 4'b0011, "R5", "write byte enables", 32'(log_be[n0+1]), 32'h3);
        end
        ti = int'(m_cur[0][7:2]);
        ri = int'(m_cur[1][7:2]);
        chk({tx_ch2, tx_ch1} == bm[ti][15:0], "R5", "tx lanes", {16'h0, tx_ch2, tx_ch1},
            {16'h0, bm[ti][15:0]});
        chk(bm[ri] == {16'hC000 | 16'(ri), b, a}, "R5", "rx word in memory", bm[ri],
            {16'hC000 | 16'(ri), b, a});
        model_adv(0, w0);
        model_adv(1, w1);
        if (dbl) exp_stat[4] = 1'b1;
        rd(I_TX_CUR, v);
        chk(v == m_cur[0], w0 ? "R4" : tag, "tx current address", v, m_cur[0]);
        rd(I_RX_CUR, v);
        chk(v == m_cur[1], w1 ? "R4" : tag, "rx current address", v, m_cur[1]);
        rd(I_STAT, v);
        chk(v == {27'h0, exp_stat}, dbl ? "R9" : "R6", "status", v, {27'h0, exp_stat});
    endtask

    initial begin
        int n0;
        logic [31:0] v;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(I_TX_CUR, v); chk(v == 0, "R1", "tx current after reset", v, 0);
        rd(I_RX_CUR, v); chk(v == 0, "R1", "rx current after reset", v, 0);
        rd(I_STAT, v);   chk(v == 0, "R1", "status after reset", v, 0);
        chk(!irq && !mem_req, "R1", "irq/mem_req after reset", {30'h0, irq, mem_req}, 0);
        chk({tx_ch2, tx_ch1} == 16'hFFFF, "R1", "tx lanes after reset", {16'h0, tx_ch2, tx_ch1}, 32'hFFFF);

        p_start[0] = 32'h40; p_mid[0] = 32'h48; p_end[0] = 32'h54;
        p_start[1] = 32'h80; p_mid[1] = 32'h84; p_end[1] = 32'h8C;
        wr(I_TX_START, p_start[0]); wr(I_TX_MID, p_mid[0]); wr(I_TX_END, p_end[0]);
        wr(I_RX_START, p_start[1]); wr(I_RX_MID, p_mid[1]); wr(I_RX_END, p_end[1]);

        // R11 strobe while stopped
        n0 = log_n;
        @(negedge clk) frame_strobe = 1'b1;
        @(negedge clk) frame_strobe = 1'b0;
        repeat (8) @(negedge clk);
        chk(log_n == n0, "R11", "no request while stopped", 32'(log_n - n0), 0);
        rd(I_TX_CUR, v); chk(v == 0, "R11", "tx current held while stopped", v, 0);

        // R2 enable loads start addresses
        wr(I_CTRL, 32'h1);
        model_load();
        rd(I_TX_CUR, v); chk(v == p_start[0], "R2", "tx current loaded on enable", v, p_start[0]);
        rd(I_RX_CUR, v); chk(v == p_start[1], "R2", "rx current loaded on enable", v, p_start[1]);

        for (int i = 0; i < 14; i++) do_xfer(int'($urandom % 4), 1'b0, "R3");

        // R9 overrun
        do_xfer(3, 1'b1, "R3");

        // R7 write-one-to-clear
        rd(I_STAT, v);
        wr(I_STAT, 32'h4);
        exp_stat[2] = 1'b0;
        rd(I_STAT, v); chk(v == {27'h0, exp_stat}, "R7", "clear bit 2 only", v, {27'h0, exp_stat});
        wr(I_STAT, 32'h0);
        rd(I_STAT, v); chk(v == {27'h0, exp_stat}, "R7", "zero write no effect", v, {27'h0, exp_stat});
        wr(I_STAT, 32'h1F);
        exp_stat = '0;
        rd(I_STAT, v); chk(v == 0, "R7", "clear all", v, 0);

        // R8 interrupt timing on rx mid-point
        wr(I_MASK, 32'h4);
        while (m_cur[1] != m_amid[1]) do_xfer(1, 1'b0, "R3");
        chk(irq == 1'b0, "R8", "irq low before mid hit", {31'h0, irq}, 0);
        begin
            bit w0, w1;
            mlat = 0;
            @(negedge clk) frame_strobe = 1'b1;
            @(negedge clk) frame_strobe = 1'b0;
            @(negedge clk);
            @(negedge clk);
            #1 chk(irq == 1'b0, "R8", "irq not yet in status cycle", {31'h0, irq}, 0);
            @(negedge clk);
            #1 chk(irq == 1'b1, "R8", "irq one clock after status", {31'h0, irq}, 1);
            repeat (8) @(negedge clk);
            model_adv(0, w0);
            model_adv(1, w1);
            rd(I_STAT, v); chk(v == {27'h0, exp_stat}, "R6", "rx mid status", v, {27'h0, exp_stat});
        end
        wr(I_MASK, 32'h0);
        repeat (2) @(negedge clk);
        chk(irq == 1'b0, "R8", "irq low when masked", {31'h0, irq}, 0);
        wr(I_MASK, 32'hF);
        repeat (2) @(negedge clk);
        chk(irq == 1'b1, "R8", "irq with all sources enabled", {31'h0, irq}, 1);

        // R10 new tx bounds wait for wrap
        p_start[0] = 32'h10; p_mid[0] = 32'h14; p_end[0] = 32'h18;
        wr(I_TX_START, p_start[0]); wr(I_TX_MID, p_mid[0]); wr(I_TX_END, p_end[0]);
        for (int i = 0; i < 10; i++) do_xfer(int'($urandom % 4), 1'b0, "R10");

        // R2 / R11 stop and restart
        wr(I_CTRL, 32'h0);
        chk({tx_ch2, tx_ch1} == 16'hFFFF, "R2", "idle pattern when stopped", {16'h0, tx_ch2, tx_ch1}, 32'hFFFF);
        n0 = log_n;
        @(negedge clk) frame_strobe = 1'b1;
        @(negedge clk) frame_strobe = 1'b0;
        repeat (8) @(negedge clk);
        chk(log_n == n0, "R11", "strobe ignored when stopped", 32'(log_n - n0), 0);
        rd(I_TX_CUR, v); chk(v == m_cur[0], "R11", "tx current held", v, m_cur[0]);
        rd(I_RX_CUR, v); chk(v == m_cur[1], "R11", "rx current held", v, m_cur[1]);
        wr(I_CTRL, 32'h1);
        model_load();
        rd(I_TX_CUR, v); chk(v == p_start[0], "R2", "tx reload on restart", v, p_start[0]);
        rd(I_RX_CUR, v); chk(v == p_start[1], "R2", "rx reload on restart", v, p_start[1]);
        do_xfer(2, 1'b0, "R3");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule